// File: doc/BRIEF.md
# Single-Step Shift Register with Arithmetic Overflow Flag

This block is an n-bit register that, on each clock edge, either loads a new word in parallel, holds its contents, or moves its contents by exactly one bit position. A 3-bit operation code selects the kind of one-position shift. There are three families of shift: logical (zero fill), rotate (the bit that leaves one end re-enters at the other) and arithmetic (sign-preserving to the right, zero fill to the left). Each family can shift left or right.

Alongside the stored word, the block drives an overflow flag. The flag is meaningful after an arithmetic left shift. It is high when the two top bits differed before the shift, which means the sign of the value changed. The block is meant to sit inside a datapath whose control logic issues one shift microoperation per cycle.

Each cycle the register takes one of five actions: reset, load, hold, shift, or a no-op shift for unused codes. A decoder turns the enables and the code into one value of an enumerated action type. The action states are HOLD, LOAD, SHL, SHR, CIL, CIR, ASHL, ASHR and NOP. The decoder moves to LOAD whenever the load enable is high. It moves to one of the six shift states, or to NOP, when only the shift enable is high. It moves to HOLD when neither enable is high.

Top module: `shuop_reg`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros and `ovf` is 0.
- R2: When `load_en` is 1, the next edge puts `load_data` into `q` and clears `ovf`, whatever the values of `shift_en` and `shift_op`. Load takes priority over shifting.
- R3: When both `load_en` and `shift_en` are 0, `q` and `ovf` keep their values.
- R4: Code 3'b000 (logical left) moves every bit up one place and puts 0 into bit 0.
- R5: Code 3'b001 (logical right) moves every bit down one place and puts 0 into bit W-1.
- R6: Code 3'b010 (rotate left) moves every bit up one place, and the old bit W-1 goes into bit 0.
- R7: Code 3'b011 (rotate right) moves every bit down one place, and the old bit 0 goes into bit W-1.
- R8: Code 3'b100 (arithmetic left) shifts as in R4. It sets `ovf` to the XOR of the old bits W-1 and W-2.
- R9: Code 3'b101 (arithmetic right) moves every bit down one place, and bit W-1 keeps its old value.
- R10: Any shift other than code 3'b100 leaves `ovf` at 0 after the edge.
- R11: Codes 3'b110 and 3'b111 with `shift_en` high leave `q` unchanged.
- R12: For W=8 and the start value 11001010, the six codes 000..101 give these results: 10010100, 01100101, 10010101, 01100101, 10010100 and 11100101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load request (highest priority) |
| load_data | input | W | Word to load |
| shift_en | input | 1 | Shift request |
| shift_op | input | 3 | Shift kind code |
| q | output | W | Register contents |
| ovf | output | 1 | Arithmetic left-shift overflow |

## Verification
The bench first loads each of the 256 possible 8-bit words and then applies each of the eight codes to it, so every pattern of fill bit, wrap bit and sign bit is tried. Words with the top two bits equal separate correct overflow detection from a flag that always sets. Words with different bottom and top bits separate rotation from zero fill. Words with the top bit set separate the arithmetic right shift from the logical one. Further sequences drive load and shift together, hold with the flag set, and a shift after an overflow, to show priority, retention and flag clearing.

// File: rtl/shuop_pkg.sv
package shuop_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_SHL  = 3'd0;
    localparam logic [OP_W-1:0] OP_SHR  = 3'd1;
    localparam logic [OP_W-1:0] OP_CIL  = 3'd2;
    localparam logic [OP_W-1:0] OP_CIR  = 3'd3;
    localparam logic [OP_W-1:0] OP_ASHL = 3'd4;
    localparam logic [OP_W-1:0] OP_ASHR = 3'd5;

    typedef enum logic [3:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_SHL,
        ACT_SHR,
        ACT_CIL,
        ACT_CIR,
        ACT_ASHL,
        ACT_ASHR,
        ACT_NOP
    } act_e;

endpackage

// File: rtl/shuop_decode.sv
module shuop_decode
    import shuop_pkg::*;
(
    input  logic            load_en,
    input  logic            shift_en,
    input  logic [OP_W-1:0] shift_op,
    output act_e            act
);

    act_e shift_act;

    always_comb begin
        unique case (shift_op)
            OP_SHL:  shift_act = ACT_SHL;
            OP_SHR:  shift_act = ACT_SHR;
            OP_CIL:  shift_act = ACT_CIL;
            OP_CIR:  shift_act = ACT_CIR;
            OP_ASHL: shift_act = ACT_ASHL;
            OP_ASHR: shift_act = ACT_ASHR;
            default: shift_act = ACT_NOP;
        endcase
    end

    // load wins over shift; idle when neither is requested
    always_comb begin
        if (load_en)       act = ACT_LOAD;
        else if (shift_en) act = shift_act;
        else               act = ACT_HOLD;
    end

endmodule

// File: rtl/shuop_shifter.sv
module shuop_shifter
    import shuop_pkg::*;
#(
    parameter int W = 8
) (
    input  act_e         act,
    input  logic [W-1:0] cur,
    output logic [W-1:0] shifted,
    output logic         go_left,
    output logic         ovf_next
);

    logic fill_lo;   // bit entering position 0 on a left move
    logic fill_hi;   // bit entering position W-1 on a right move
    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    always_comb begin
        go_left = 1'b0;
        fill_lo = 1'b0;
        fill_hi = 1'b0;
        unique case (act)
            ACT_SHL:  go_left = 1'b1;
            ACT_ASHL: go_left = 1'b1;
            ACT_CIL: begin
                go_left = 1'b1;
                fill_lo = cur[W-1];
            end
            ACT_CIR:  fill_hi = cur[0];
            ACT_ASHR: fill_hi = cur[W-1];
            default: begin
                go_left = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign up_v[i] = fill_lo;
        end else begin : g_lo_mid
            assign up_v[i] = cur[i-1];
        end
        if (i == W-1) begin : g_hi
            assign dn_v[i] = fill_hi;
        end else begin : g_hi_mid
            assign dn_v[i] = cur[i+1];
        end
        assign shifted[i] = go_left ? up_v[i] : dn_v[i];
    end

    assign ovf_next = (act == ACT_ASHL) ? (cur[W-1] ^ cur[W-2]) : 1'b0;

endmodule

// File: rtl/shuop_reg.sv
module shuop_reg
    import shuop_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         shift_en,
    input  logic [2:0]   shift_op,
    output logic [W-1:0] q,
    output logic         ovf
);

    act_e         act;
    logic [W-1:0] shifted;
    logic         go_left;
    logic         ovf_next;
    logic [W-1:0] q_next;
    logic         ovf_d;

    shuop_decode u_dec (
        .load_en  (load_en),
        .shift_en (shift_en),
        .shift_op (shift_op),
        .act      (act)
    );

    shuop_shifter #(.W(W)) u_shf (
        .act      (act),
        .cur      (q),
        .shifted  (shifted),
        .go_left  (go_left),
        .ovf_next (ovf_next)
    );

    // next-state selection by action
    always_comb begin
        q_next = q;
        ovf_d  = ovf;
        unique case (act)
            ACT_HOLD: begin
                q_next = q;
                ovf_d  = ovf;
            end
            ACT_LOAD: begin
                q_next = load_data;
                ovf_d  = 1'b0;
            end
            ACT_NOP: begin
                q_next = q;
                ovf_d  = 1'b0;
            end
            default: begin
                q_next = shifted;
                ovf_d  = ovf_next;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else begin
            q   <= q_next;
            ovf <= ovf_d;
        end
    end

    logic unused_dir;
    assign unused_dir = go_left;

endmodule

// File: rtl/shuop_reg_chk.sv
module shuop_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_en,
    input logic [W-1:0] load_data,
    input logic         shift_en,
    input logic [2:0]   shift_op,
    input logic [W-1:0] q,
    input logic         ovf
);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (q == $past(load_data)) && !ovf);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(q) && $stable(ovf));

    p_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && shift_op == 3'd4)
        |=> ovf == ($past(q[W-1]) ^ $past(q[W-2])));

    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && shift_op == 3'd5) |=> q[W-1] == $past(q[W-1]));

    p_ovf_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && shift_op != 3'd4) |=> !ovf);

    p_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && shift_op[2:1] == 2'b11) |=> $stable(q));

    p_zero_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && shift_op == 3'd0) |=> !q[0]);

endmodule

bind shuop_reg shuop_reg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (load_data),
    .shift_en  (shift_en),
    .shift_op  (shift_op),
    .q         (q),
    .ovf       (ovf)
);

// File: tb/shuop_reg_tb.sv
`timescale 1ns/1ps
module shuop_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_data = '0;
    logic         shift_en = 1'b0;
    logic [2:0]   shift_op = 3'd0;
    logic [W-1:0] q;
    logic         ovf;

    int nvec = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    shuop_reg #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .shift_en(shift_en), .shift_op(shift_op), .q(q), .ovf(ovf)
    );

    task automatic chk(string req, logic [W-1:0] eq, logic eo);
        nvec++;
        if (q !== eq || ovf !== eo) begin
            nbad++;
            $display("FAIL %s q=%b ovf=%b expected q=%b ovf=%b", req, q, ovf, eq, eo);
        end
    endtask

    task automatic step(logic le, logic [W-1:0] d, logic se, logic [2:0] op);
        load_en = le; load_data = d; shift_en = se; shift_op = op;
        @(posedge clk); #1;
    endtask

    function automatic logic [W-1:0] model(logic [W-1:0] v, logic [2:0] op);
        int x;
        x = int'(v);
        case (op)
            3'd0: return W'((x * 2) % 256);
            3'd1: return W'(x / 2);
            3'd2: return W'((x * 2) % 256 + x / 128);
            3'd3: return W'(x / 2 + (x % 2) * 128);
            3'd4: return W'((x * 2) % 256);
            3'd5: return W'(x / 2 + ((x >= 128) ? 128 : 0));
            default: return v;
        endcase
    endfunction

    function automatic string tag(logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R11";
        endcase
    endfunction

    initial begin
        #(5.0 * 200000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [W-1:0] ex;
        logic         eo;
        // R1: reset state
        #3;
        chk("R1", '0, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", '0, 1'b0);

        // exhaustive sweep: every word, every code
        for (int v = 0; v < 256; v++) begin
            for (int op = 0; op < 8; op++) begin
                step(1'b1, W'(v), 1'b0, 3'(op));
                if (op == 0) chk("R2", W'(v), 1'b0);
                step(1'b0, '0, 1'b1, 3'(op));
                ex = model(W'(v), 3'(op));
                eo = (op == 4) ? (((v >> 7) ^ (v >> 6)) & 1) != 0 : 1'b0;
                chk(tag(3'(op)), ex, eo);
                if (op != 4) chk("R10", ex, 1'b0);
            end
        end

        // R12: worked example
        for (int op = 0; op < 6; op++) begin
            step(1'b1, 8'b1100_1010, 1'b0, 3'd0);
            step(1'b0, '0, 1'b1, 3'(op));
            case (op)
                0: ex = 8'b1001_0100;
                1: ex = 8'b0110_0101;
                2: ex = 8'b1001_0101;
                3: ex = 8'b0110_0101;
                4: ex = 8'b1001_0100;
                default: ex = 8'b1110_0101;
            endcase
            chk("R12", ex, (op == 4) ? 1'b0 : 1'b0);
        end

        // R3: hold keeps a set overflow flag and the word
        step(1'b1, 8'b1000_0001, 1'b0, 3'd0);
        step(1'b0, '0, 1'b1, 3'd4);
        chk("R8", 8'b0000_0010, 1'b1);
        step(1'b0, 8'hFF, 1'b0, 3'd1);
        chk("R3", 8'b0000_0010, 1'b1);
        step(1'b0, 8'h55, 1'b0, 3'd4);
        chk("R3", 8'b0000_0010, 1'b1);

        // R2: load wins over a shift request and clears the flag
        step(1'b1, 8'h3C, 1'b1, 3'd4);
        chk("R2", 8'h3C, 1'b0);

        // R10: reserved code after overflow clears the flag, word unchanged
        step(1'b1, 8'h40, 1'b0, 3'd0);
        step(1'b0, '0, 1'b1, 3'd4);
        chk("R8", 8'h80, 1'b1);
        step(1'b0, '0, 1'b1, 3'd7);
        chk("R10", 8'h80, 1'b0);

        // R1: asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1 chk("R1", '0, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule